// File: doc/BRIEF.md
# Timer Input Capture Unit

This block sits next to a free-running timer counter and records when external events happen. It has up to four capture channels. Each channel watches one input pin and, on the edge chosen by software, copies the current counter value into its own capture register. It then raises a per-channel flag in a status register. Each flag, and the counter update flag, can drive a single combined interrupt line through an enable mask.

Software sets the unit up through a small word-addressed register port. A channel's select field routes its own pin into the capture path. Its control nibble turns capture on and chooses rising, falling or both edges. Flags are cleared by writing zero to them, so one store can clear chosen flags and leave the others untouched. The counter value and the counter update pulse come from outside the block.

Top module: `icap_unit`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: With pin selected (select field 01), capture enabled and polarity bits 00, a rising pin edge loads the capture register with the `cnt_value` present at the third rising clock edge after the pin changes. Nothing changes before that edge.
- R3: Polarity 10 (polarity bit set, complementary bit clear) captures falling edges only. A rising edge leaves the capture register and flag unchanged.
- R4: Polarity 11 captures on both rising and falling edges.
- R5: A channel whose enable bit is 0, or whose select field is not 01, never captures and never sets its flag.
- R6: A capture on channel x (0..3) sets status bit x+1. A high `cnt_update` sets status bit 0.
- R7: A status write clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged.
- R8: When a capture and a write-0 to the same flag fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when some status bit and its enable bit (same position) are both 1.
- R10: A flag stays set when its channel is disabled and when it is enabled again, until software writes 0 to it.
- R11: For channels at or above `NCH`, writes to their fields, control bits, flags and enables have no effect, and their capture register reads zero.
- R12: Register map (word address): 0 status, 1 interrupt enable, 2 mode A (channel 0 select at [1:0], channel 1 at [9:8]), 3 mode B (channel 2 at [1:0], channel 3 at [9:8]), 4 control (channel x nibble at 4x: bit 0 enable, bit 1 polarity, bit 3 complementary polarity), 8+x capture register of channel x. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cnt_value | input | CNT_W | Current timer counter value |
| cnt_update | input | 1 | Counter update/overflow pulse |
| cap_pin | input | 4 | Capture input pins, one per channel |
| irq | output | 1 | Combined interrupt |

## Verification
Random channel setups are drawn for enable, select field and polarity, and each is paired with a pin toggle in a random direction. Each result is compared with a model, which separates the polarity modes and the arming conditions from each other. Directed cases step a single rising edge cycle by cycle to pin down the capture latency and the exact counter value taken. They place a status clear in the same cycle as a capture to show which one wins. They mix 0 and 1 write data to show that a 1 leaves a flag alone. A build with three channels shows that the absent fourth channel ignores writes and pin activity.

// File: rtl/icap_pkg.sv
// Package: register word addresses shared by the capture unit and its users.
// Assumes a word-addressed port; capture registers occupy a 4-word aligned block.
package icap_pkg;
    localparam int MAX_CH   = 4;
    localparam int A_STATUS = 0;
    localparam int A_IEN    = 1;
    localparam int A_MODE_A = 2;
    localparam int A_MODE_B = 3;
    localparam int A_CTL    = 4;
    localparam int A_CAP0   = 8;
    localparam logic [1:0] SEL_OWN_PIN = 2'b01;
endpackage

// File: rtl/icap_edge.sv
// Module: two-flop synchroniser and edge qualifier for one capture pin.
// Assumes pin is asynchronous to clk. Output hit is a one-cycle pulse
// when the synchronised pin shows the edge picked by pol/cpol.
module icap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    input  logic cpol,
    output logic hit
);
    logic s1, s2, s3;

    // Synchronise the pin and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Pick rising, falling or both edges from the polarity pair.
    always_comb begin
        if (pol && cpol)
            hit = s2 ^ s3;
        else if (pol)
            hit = !s2 && s3;
        else
            hit = s2 && !s3;
    end
endmodule

// File: rtl/icap_channel.sv
// Module: one capture channel: select field, control bits, edge path and
// capture register. Assumes write strobes are already address-decoded.
module icap_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [1:0]       sel_in,
    input  logic             wr_ctl,
    input  logic [3:0]       ctl_in,
    input  logic             pin,
    input  logic [CNT_W-1:0] cnt_value,
    output logic [1:0]       sel_rb,
    output logic [3:0]       ctl_rb,
    output logic [CNT_W-1:0] cap_q,
    output logic             cap_evt
);
    import icap_pkg::*;

    logic en_q, pol_q, cpol_q, hit;

    // Hold the input-select field.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_rb <= 2'b00;
        else if (wr_sel) sel_rb <= sel_in;
    end

    // Hold enable and polarity bits; the spare nibble bit is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pol_q  <= 1'b0;
            cpol_q <= 1'b0;
        end else if (wr_ctl) begin
            en_q   <= ctl_in[0];
            pol_q  <= ctl_in[1];
            cpol_q <= ctl_in[3];
        end
    end

    assign ctl_rb = {cpol_q, 1'b0, pol_q, en_q};

    icap_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin),
        .pol   (pol_q),
        .cpol  (cpol_q),
        .hit   (hit)
    );

    assign cap_evt = hit && en_q && (sel_rb == SEL_OWN_PIN);

    // Latch the counter on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= cnt_value;
    end

    // R2: a capture takes the counter value of that very cycle.
    a_r2_latch_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_q == $past(cnt_value));
    // R5: without a capture event the register holds.
    a_r5_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_q));
endmodule

// File: rtl/icap_unit.sv
// Module: top of the input capture unit: register port, status and
// interrupt-enable registers, and NCH channels (NCH <= 4).
// Assumes one-cycle write strobes; reads are combinational.
module icap_unit #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [CNT_W-1:0]  cnt_value,
    input  logic              cnt_update,
    input  logic [3:0]        cap_pin,
    output logic              irq
);
    import icap_pkg::*;

    localparam int NFLAG = NCH + 1;
    localparam logic [MAX_CH:0] FLAG_MASK = (MAX_CH+1)'((1 << NFLAG) - 1);

    logic [MAX_CH:0]  status_q, status_d, ien_q;
    logic [MAX_CH-1:0] cap_evt;
    logic [1:0]       sel_rb [MAX_CH];
    logic [3:0]       ctl_rb [MAX_CH];
    logic [CNT_W-1:0] cap_rb [MAX_CH];
    logic wr_status, wr_ien, wr_ctl;
    logic unused_wdata;

    assign wr_status = bus_wr && (bus_addr == ADDR_W'(A_STATUS));
    assign wr_ien    = bus_wr && (bus_addr == ADDR_W'(A_IEN));
    assign wr_ctl    = bus_wr && (bus_addr == ADDR_W'(A_CTL));
    assign unused_wdata = ^bus_wdata[31:16];

    genvar i;
    generate
        for (i = 0; i < MAX_CH; i++) begin : g_ch
            if (i < NCH) begin : g_on
                localparam int MREG = (i < 2) ? A_MODE_A : A_MODE_B;
                localparam int MOFF = (i % 2) * 8;
                icap_channel #(.CNT_W(CNT_W)) u_ch (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .wr_sel    (bus_wr && (bus_addr == ADDR_W'(MREG))),
                    .sel_in    (bus_wdata[MOFF +: 2]),
                    .wr_ctl    (wr_ctl),
                    .ctl_in    (bus_wdata[4*i +: 4]),
                    .pin       (cap_pin[i]),
                    .cnt_value (cnt_value),
                    .sel_rb    (sel_rb[i]),
                    .ctl_rb    (ctl_rb[i]),
                    .cap_q     (cap_rb[i]),
                    .cap_evt   (cap_evt[i])
                );
                // R8: a capture leaves its flag set, even against a clear.
                a_r8_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
                    cap_evt[i] |=> status_q[i+1]);
            end else begin : g_off
                assign sel_rb[i]  = 2'b00;
                assign ctl_rb[i]  = 4'b0000;
                assign cap_rb[i]  = '0;
                assign cap_evt[i] = 1'b0;
            end
        end
    endgenerate

    // Next status: write-0 clears, then hardware events set.
    always_comb begin
        status_d = status_q;
        if (wr_status) status_d = status_d & bus_wdata[MAX_CH:0];
        status_d = (status_d | {cap_evt, cnt_update}) & FLAG_MASK;
    end

    // Status and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            ien_q    <= '0;
        end else begin
            status_q <= status_d;
            if (wr_ien) ien_q <= bus_wdata[MAX_CH:0] & FLAG_MASK;
        end
    end

    assign irq = |(status_q & ien_q);

    // Read mux; unlisted bits and addresses return zero.
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            A_STATUS: bus_rdata[MAX_CH:0] = status_q;
            A_IEN:    bus_rdata[MAX_CH:0] = ien_q;
            A_MODE_A: begin
                bus_rdata[1:0] = sel_rb[0];
                bus_rdata[9:8] = sel_rb[1];
            end
            A_MODE_B: begin
                bus_rdata[1:0] = sel_rb[2];
                bus_rdata[9:8] = sel_rb[3];
            end
            A_CTL: begin
                for (int k = 0; k < MAX_CH; k++) bus_rdata[4*k +: 4] = ctl_rb[k];
            end
            A_CAP0, A_CAP0+1, A_CAP0+2, A_CAP0+3:
                bus_rdata[CNT_W-1:0] = cap_rb[bus_addr[1:0]];
            default: bus_rdata = '0;
        endcase
    end

    // R6: an update pulse always sets flag 0.
    a_r6_update_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_update |=> status_q[0]);
    // R7: writing 0 to flag 0 with no update pending clears it.
    a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !bus_wdata[0] && !cnt_update) |=> !status_q[0]);
    // R9: no enables means no interrupt.
    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
    // R1: reset leaves the interrupt low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: tb/icap_unit_test.sv
`timescale 1ns/1ps
module icap_unit_test;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] cnt_value = 32'h1000_0000;
    logic        cnt_update = 1'b0;
    logic [3:0]  cap_pin = '0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_cap [4];

    icap_unit #(.NCH(NCH), .CNT_W(32), .ADDR_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_value(cnt_value),
        .cnt_update(cnt_update), .cap_pin(cap_pin), .irq(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cnt_value <= cnt_value + 32'd1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        bus_addr = 4'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic toggle(int ch, output logic [31:0] v);
        @(negedge clk);
        v = cnt_value;
        cap_pin[ch] = ~cap_pin[ch];
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit edge_ok(bit pol, bit cpol, bit oldv, bit newv);
        if (pol && cpol) return 1'b1;
        if (pol) return oldv && !newv;
        return !oldv && newv;
    endfunction

    function automatic logic [31:0] mode_word(int ch, int regsel, logic [1:0] s);
        logic [31:0] w = '0;
        if (regsel == 0 && ch == 0) w[1:0] = s;
        if (regsel == 0 && ch == 1) w[9:8] = s;
        if (regsel == 1 && ch == 2) w[1:0] = s;
        return w;
    endfunction

    task automatic setup(int ch, bit en, logic [1:0] s, bit pol, bit cpol);
        wr(2, mode_word(ch, 0, s));
        wr(3, mode_word(ch, 1, s));
        wr(4, 32'({cpol, 1'b0, pol, en}) << (4*ch));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d, v;
        void'($urandom(32'd20240307));
        for (int k = 0; k < 4; k++) exp_cap[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(0, d); chk("R1 status", d, 0);
        rd(1, d); chk("R1 ien", d, 0);
        rd(4, d); chk("R1 ctl", d, 0);
        rd(8, d); chk("R1 cap0", d, 0);
        chk("R1 irq", 32'(irq), 0);

        // R12: layout and reserved bits
        wr(4, 32'hFFFF_FFFF); rd(4, d); chk("R12 ctl readback", d, 32'h0000_0BBB);
        wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R12 mode A readback", d, 32'h0000_0303);
        wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R12 ien readback", d, 32'h0000_000F);
        // R11: absent channel 3
        wr(3, 32'hFFFF_FFFF); rd(3, d); chk("R11 mode B ch3 field", d, 32'h0000_0003);
        toggle(3, v); settle();
        rd(11, d); chk("R11 cap3 reads zero", d, 0);
        rd(0, d); chk("R11 flag4 stays zero", d, 0);
        wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0);

        // R2: rising edge latency and value on channel 0
        setup(0, 1, 2'b01, 0, 0);
        toggle(0, v);
        repeat (2) @(posedge clk); @(negedge clk);
        rd(8, d); chk("R2 no capture before third edge", d, 0);
        @(posedge clk); @(negedge clk);
        rd(8, d); chk("R2 captured value", d, v + 32'd2);
        exp_cap[0] = v + 32'd2;
        rd(0, d); chk("R6 flag bit1", d, 32'h2);
        toggle(0, v); settle();
        rd(8, d); chk("R2 falling ignored in rising mode", d, exp_cap[0]);

        // R3: falling-only on channel 1
        wr(0, 0);
        setup(1, 1, 2'b01, 1, 0);
        toggle(1, v); settle();
        rd(9, d); chk("R3 rising ignored", d, 0);
        rd(0, d); chk("R3 no flag on rising", d, 0);
        toggle(1, v); settle();
        rd(9, d); chk("R3 falling captured", d, v + 32'd2);
        exp_cap[1] = v + 32'd2;
        rd(0, d); chk("R6 flag bit2", d, 32'h4);

        // R4: both edges on channel 2
        wr(0, 0);
        setup(2, 1, 2'b01, 1, 1);
        toggle(2, v); settle();
        rd(10, d); chk("R4 rising captured", d, v + 32'd2);
        toggle(2, v); settle();
        rd(10, d); chk("R4 falling captured", d, v + 32'd2);
        exp_cap[2] = v + 32'd2;

        // R5: disabled or wrong select
        setup(2, 0, 2'b01, 1, 1);
        wr(0, 0);
        toggle(2, v); settle();
        rd(10, d); chk("R5 disabled no capture", d, exp_cap[2]);
        setup(2, 1, 2'b10, 1, 1);
        toggle(2, v); settle();
        rd(10, d); chk("R5 bad select no capture", d, exp_cap[2]);
        rd(0, d); chk("R5 no flag", d, 0);

        // R6/R7: update flag, selective clear
        @(negedge clk); cnt_update = 1'b1; @(negedge clk); cnt_update = 1'b0;
        setup(0, 1, 2'b01, 1, 1);
        toggle(0, v); settle();
        exp_cap[0] = v + 32'd2;
        rd(0, d); chk("R6 update and ch0 flags", d, 32'h3);
        wr(0, 32'hFFFF_FFFD); rd(0, d); chk("R7 clear bit1 only", d, 32'h1);
        wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R7 write ones keeps", d, 32'h1);

        // R9: interrupt masking
        chk("R9 irq off with no enables", 32'(irq), 0);
        wr(1, 32'h2); #1; chk("R9 irq off other enable", 32'(irq), 0);
        wr(1, 32'h1); #1; chk("R9 irq on matched", 32'(irq), 1);
        wr(0, 0); #1; chk("R9 irq off after clear", 32'(irq), 0);

        // R8: capture and clear in the same cycle
        toggle(0, v);
        @(negedge clk);
        wr(0, 32'h0);
        rd(0, d); chk("R8 capture beats clear", d, 32'h2);
        rd(8, d); chk("R8 value", d, v + 32'd2);
        exp_cap[0] = v + 32'd2;

        // R10: pending flag across disable and re-enable
        wr(4, 0); rd(0, d); chk("R10 kept while disabled", d, 32'h2);
        setup(0, 1, 2'b01, 1, 1); rd(0, d); chk("R10 pending on enable", d, 32'h2);
        wr(1, 32'h2); #1; chk("R10 irq from pending flag", 32'(irq), 1);
        wr(1, 0); wr(0, 0);

        // Random phase over R2-R6
        for (int it = 0; it < 60; it++) begin
            int ch; bit en, pol, cpol, oldv, hit; logic [1:0] s;
            ch   = int'($urandom % 3);
            en   = ($urandom % 4) != 0;
            s    = (($urandom % 3) == 0) ? 2'($urandom) : 2'b01;
            pol  = 1'($urandom);
            cpol = 1'($urandom);
            setup(ch, en, s, pol, cpol);
            wr(0, 0);
            oldv = cap_pin[ch];
            toggle(ch, v);
            hit = en && (s == 2'b01) && edge_ok(pol, cpol, oldv, !oldv);
            if (hit) exp_cap[ch] = v + 32'd2;
            settle();
            rd(8 + ch, d); chk("R2-R5 random capture", d, exp_cap[ch]);
            rd(0, d); chk("R6 random flag", d, hit ? (32'h1 << (ch + 1)) : 32'h0);
        end

        summary();
    end
endmodule